// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Match Alarm

This block is the timekeeping core of a real-time clock. It holds a seconds count of `CNT_W` bits (32 by default) that advances by one on every clock cycle in which the one-second enable pulse is high. The pulse must come from a divider outside this block. Software reaches the block over a plain single-cycle register bus. Through that bus it can preset the count, read the count, stop or start counting, and program a compare value.

When a counting step makes the count equal to the compare value, a sticky alarm flag is set. The flag has a mask, a masked view and a write-one-to-clear register, and it drives a single level-sensitive interrupt line. Reads are combinational. A write takes effect at the clock edge on which it is presented.

Top module: `secrtc_core`

## Requirements
- R1: After reset the count, compare value, mask and alarm flag are all zero, the run bit (bit 0 of the control register at 0x0C) is 1, and `alarm_irq` is low.
- R2: Reading offset 0x00 returns the current count. A write to offset 0x08 sets the count to the written value at that clock edge. Reading 0x08 returns the last value written there.
- R3: The count increases by one on each edge where `tick_1hz` is high and the run bit is 1. The count holds when `tick_1hz` is low or the run bit is 0. The count wraps from all-ones to zero, and a preset at 0x08 takes priority over a step in the same cycle.
- R4: The compare value at offset 0x04 can be written and read back over its full width.
- R5: Bit 0 of offset 0x14 (raw alarm) is set on the counting step that makes the count equal to the compare value. This includes the step that wraps to zero. Presetting the count to the compare value does not set the bit.
- R6: The raw alarm bit stays set after the count moves past the compare value. Writing 1 to bit 0 of offset 0x1C clears it, and writing 0 there leaves it set.
- R7: If a setting step and a clearing write fall on the same edge, the raw alarm bit ends up set.
- R8: Bit 0 of offset 0x10 is the alarm mask. It can be read back, and its other bits read 0. Offset 0x18 bit 0 reads raw AND mask. `alarm_irq` is high exactly when that masked bit is 1.
- R9: Writes to 0x00, 0x14 and 0x18 change nothing. Reads of 0x1C, of any offset above 0x1C, and of any address whose two low bits are not zero return 0.
- R10: In the control register at 0x0C only bit 0 is stored. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse marking a second |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (6) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access, 0 otherwise |
| alarm_irq | output | 1 | Alarm interrupt, active high |

## Verification
The bench aims at the edges of the alarm path. It sets the alarm from the step that wraps all-ones to zero, which a design comparing the old count or ignoring the carry would miss. It presets the count straight onto the compare value, which a design comparing the live count would wrongly flag. It lands a clear write on the same edge as a setting step, where a clear-first design loses the alarm. It also checks that a zero written to the clear register, and writes to the read-only offsets, leave the flag and the count untouched, and that masking hides the line without losing the raw flag.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

    localparam int DATA_W = 32;
    localparam int WIDX_W = 3;

    // Word index of each register (byte offset / 4).
    typedef enum logic [WIDX_W-1:0] {
        W_VALUE = 3'd0,
        W_MATCH = 3'd1,
        W_LOAD  = 3'd2,
        W_CTRL  = 3'd3,
        W_MASK  = 3'd4,
        W_RAW   = 3'd5,
        W_MSKD  = 3'd6,
        W_ICLR  = 3'd7
    } word_e;

    // Decoded write strobes, one per writable register.
    typedef struct packed {
        logic match;
        logic load;
        logic ctrl;
        logic mask;
        logic iclr;
    } wstrb_t;

    localparam wstrb_t WSTRB_NONE = '{default: 1'b0};

    function automatic wstrb_t decode_write(input logic hit, input word_e w);
        wstrb_t s;
        s = WSTRB_NONE;
        if (hit) begin
            unique case (w)
                W_MATCH: s.match = 1'b1;
                W_LOAD:  s.load  = 1'b1;
                W_CTRL:  s.ctrl  = 1'b1;
                W_MASK:  s.mask  = 1'b1;
                W_ICLR:  s.iclr  = 1'b1;
                default: s = WSTRB_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/secrtc_counter.sv
module secrtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] match_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_nxt;
    logic             step;

    assign cnt_nxt = cnt_q + CNT_W'(1);
    assign step    = tick && run && !load_en;
    // The alarm fires on the step that lands on the compare value.
    assign hit     = step && (cnt_nxt == match_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_en) begin
            cnt_q <= load_val;
        end else if (step) begin
            cnt_q <= cnt_nxt;
        end
    end
endmodule

// File: rtl/secrtc_irq.sv
module secrtc_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic mask_bit,
    output logic raw_q,
    output logic masked,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= 1'b0;
        end else if (set_ev) begin
            raw_q <= 1'b1;          // a set beats a clear on the same edge
        end else if (clr_ev) begin
            raw_q <= 1'b0;
        end
    end

    assign masked = raw_q & mask_bit;
    assign irq    = masked;
endmodule

// File: rtl/secrtc_regif.sv
module secrtc_regif
    import secrtc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    input  logic              masked,
    output logic [DATA_W-1:0] rdata,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic [CNT_W-1:0]  match_q,
    output logic              run_q,
    output logic              mask_q,
    output logic              clr_ev
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    word_e            word;
    wstrb_t           ws;
    logic [CNT_W-1:0] load_shadow_q;

    assign idx    = addr[ADDR_W-1:2];
    assign mapped = (addr[1:0] == 2'b00) && (idx < IDX_W'(8));
    assign word   = word_e'(idx[WIDX_W-1:0]);
    assign ws     = decode_write(sel && wr && mapped, word);

    assign load_en  = ws.load;
    assign load_val = wdata[CNT_W-1:0];
    assign clr_ev   = ws.iclr && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q       <= '0;
            load_shadow_q <= '0;
            run_q         <= 1'b1;
            mask_q        <= 1'b0;
        end else begin
            if (ws.match) match_q       <= wdata[CNT_W-1:0];
            if (ws.load)  load_shadow_q <= wdata[CNT_W-1:0];
            if (ws.ctrl)  run_q         <= wdata[0];
            if (ws.mask)  mask_q        <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr && mapped) begin
            unique case (word)
                W_VALUE: rdata = DATA_W'(cnt);
                W_MATCH: rdata = DATA_W'(match_q);
                W_LOAD:  rdata = DATA_W'(load_shadow_q);
                W_CTRL:  rdata = DATA_W'(run_q);
                W_MASK:  rdata = DATA_W'(mask_q);
                W_RAW:   rdata = DATA_W'(raw);
                W_MSKD:  rdata = DATA_W'(masked);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/secrtc_core.sv
module secrtc_core
    import secrtc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              alarm_irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] match_q;
    logic [CNT_W-1:0] load_val;
    logic             load_en;
    logic             run_q;
    logic             mask_q;
    logic             clr_ev;
    logic             hit;
    logic             raw_q;
    logic             masked;

    secrtc_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt_q), .raw(raw_q), .masked(masked),
        .rdata(bus_rdata), .load_en(load_en), .load_val(load_val),
        .match_q(match_q), .run_q(run_q), .mask_q(mask_q), .clr_ev(clr_ev)
    );

    secrtc_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .tick(tick_1hz), .run(run_q),
        .load_en(load_en), .load_val(load_val), .match_val(match_q),
        .cnt_q(cnt_q), .hit(hit)
    );

    secrtc_irq u_irq (
        .clk(clk), .rst(rst), .set_ev(hit), .clr_ev(clr_ev),
        .mask_bit(mask_q), .raw_q(raw_q), .masked(masked), .irq(alarm_irq)
    );
endmodule

// File: rtl/secrtc_chk.sv
module secrtc_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             run,
    input logic             load_en,
    input logic [CNT_W-1:0] load_val,
    input logic [CNT_W-1:0] cnt,
    input logic             hit,
    input logic             clr_ev,
    input logic             raw,
    input logic             mask,
    input logic             irq
);
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> cnt == $past(load_val));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && run && !load_en) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !(tick && run)) |=> $stable(cnt));

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        hit |=> raw);

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (raw && !clr_ev) |=> raw);

    p_nospur_r5: assert property (@(posedge clk) disable iff (rst)
        (!raw && !hit) |=> !raw);

    p_setwins_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_ev) |=> raw);

    p_irq_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (raw && mask));
endmodule

bind secrtc_core secrtc_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_1hz), .run(run_q), .load_en(load_en),
    .load_val(load_val), .cnt(cnt_q), .hit(hit), .clr_ev(clr_ev),
    .raw(raw_q), .mask(mask_q), .irq(alarm_irq)
);

// File: tb/secrtc_core_tb.sv
`timescale 1ns/1ps
module secrtc_core_tb_top;
    localparam int ADDR_W = 6;
    localparam int NV = 23;
    localparam int WD_CYCLES = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_1hz = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    secrtc_core #(.ADDR_W(ADDR_W), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    // {write, byte addr, write data, expected read data}
    localparam logic [70:0] VECS [0:NV-1] = '{
        {1'b0, 6'h00, 32'h0,         32'h0},         // R1 count after reset
        {1'b0, 6'h0C, 32'h0,         32'h1},         // R1 run bit after reset
        {1'b1, 6'h04, 32'h10,        32'h0},
        {1'b0, 6'h04, 32'h0,         32'h10},        // R4
        {1'b1, 6'h04, 32'hA5A55A5A,  32'h0},
        {1'b0, 6'h04, 32'h0,         32'hA5A55A5A},  // R4 full width
        {1'b1, 6'h08, 32'h5,         32'h0},
        {1'b0, 6'h00, 32'h0,         32'h5},         // R2 load then read
        {1'b0, 6'h08, 32'h0,         32'h5},         // R2 load readback
        {1'b1, 6'h00, 32'hDEADBEEF,  32'h0},
        {1'b0, 6'h00, 32'h0,         32'h5},         // R9 write to 0x00 ignored
        {1'b1, 6'h10, 32'hFFFFFFFF,  32'h0},
        {1'b0, 6'h10, 32'h0,         32'h1},         // R8 mask readback bit 0
        {1'b1, 6'h10, 32'h0,         32'h0},
        {1'b1, 6'h14, 32'h1,         32'h0},
        {1'b0, 6'h14, 32'h0,         32'h0},         // R9 raw is read-only
        {1'b1, 6'h18, 32'h1,         32'h0},
        {1'b0, 6'h18, 32'h0,         32'h0},         // R9 masked is read-only
        {1'b0, 6'h1C, 32'h0,         32'h0},         // R9 clear reads 0
        {1'b0, 6'h24, 32'h0,         32'h0},         // R9 unmapped reads 0
        {1'b1, 6'h0C, 32'hFFFFFFFF,  32'h0},
        {1'b0, 6'h0C, 32'h0,         32'h1},         // R10 control only bit 0
        {1'b0, 6'h06, 32'h0,         32'h0}          // R9 misaligned reads 0
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
            @(negedge clk); tick_1hz = 1'b0;
        end
    endtask

    task automatic rd_check(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        #1 check("R1 irq after reset", 32'(alarm_irq), 32'h0);
        rd_check("R1 raw after reset", 6'h14, 32'h0);
        rd_check("R1 mask after reset", 6'h10, 32'h0);
        rd_check("R1 match after reset", 6'h04, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i][70]) begin
                bus_write(VECS[i][69:64], VECS[i][63:32]);
            end else begin
                logic [31:0] d;
                bus_read(VECS[i][69:64], d);
                check($sformatf("table row %0d (R1/R2/R4/R8/R9/R10)", i), d, VECS[i][31:0]);
            end
        end

        // R3 stepping, stop, wrap
        bus_write(6'h04, 32'h1000);
        bus_write(6'h08, 32'd10);
        ticks(3);
        rd_check("R3 three steps", 6'h00, 32'd13);
        bus_write(6'h0C, 32'h0);
        ticks(2);
        rd_check("R3 stopped holds", 6'h00, 32'd13);
        bus_write(6'h0C, 32'h1);
        repeat (4) @(negedge clk);
        rd_check("R3 no tick holds", 6'h00, 32'd13);
        @(negedge clk);
        tick_1hz = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'd40;
        @(negedge clk);
        tick_1hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_check("R3 load beats step", 6'h00, 32'd40);

        // R3 R5 wrap onto compare value zero
        bus_write(6'h04, 32'h0);
        bus_write(6'h08, 32'hFFFFFFFF);
        rd_check("R5 no alarm before wrap", 6'h14, 32'h0);
        ticks(1);
        rd_check("R3 wrap to zero", 6'h00, 32'h0);
        rd_check("R5 alarm on wrap", 6'h14, 32'h1);
        bus_write(6'h1C, 32'h1);
        rd_check("R6 cleared", 6'h14, 32'h0);

        // R5 R6 ordinary match and stickiness
        bus_write(6'h04, 32'd20);
        bus_write(6'h08, 32'd18);
        ticks(1);
        rd_check("R5 not yet equal", 6'h14, 32'h0);
        ticks(1);
        rd_check("R5 set on reaching match", 6'h14, 32'h1);
        ticks(1);
        rd_check("R6 sticky past match", 6'h14, 32'h1);
        bus_write(6'h1C, 32'h0);
        rd_check("R6 write 0 keeps flag", 6'h14, 32'h1);
        bus_write(6'h1C, 32'h1);
        rd_check("R6 write 1 clears", 6'h14, 32'h0);
        bus_write(6'h08, 32'd20);
        rd_check("R5 preset onto match no alarm", 6'h14, 32'h0);

        // R8 mask and interrupt line
        bus_write(6'h10, 32'h1);
        #1 check("R8 irq low with raw clear", 32'(alarm_irq), 32'h0);
        bus_write(6'h08, 32'd19);
        ticks(1);
        #1 check("R8 irq high when masked set", 32'(alarm_irq), 32'h1);
        rd_check("R8 masked status", 6'h18, 32'h1);
        bus_write(6'h10, 32'h0);
        #1 check("R8 irq low when masked off", 32'(alarm_irq), 32'h0);
        rd_check("R8 masked status off", 6'h18, 32'h0);
        rd_check("R8 raw kept under mask", 6'h14, 32'h1);

        // R7 set and clear on the same edge
        bus_write(6'h1C, 32'h1);
        bus_write(6'h04, 32'd30);
        bus_write(6'h08, 32'd29);
        @(negedge clk);
        tick_1hz = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h1;
        @(negedge clk);
        tick_1hz = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        rd_check("R7 set wins over clear", 6'h14, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule